// File: doc/BRIEF.md
# Vertical sync pulse extractor

This block watches a digital, active-low composite sync stream that has already been sliced from a video signal. It runs from one fixed system clock. It measures every low pulse of the stream in clock counts, and it produces one low-going vertical sync pulse at the start of each field. Line timing is given as a number of clocks per nominal line.

Each low pulse is sorted by its low time and by its distance from the previous falling edge. A low time above a quarter line is a broad (serration) pulse. A short pulse that follows the previous one by less than three quarters of a line is an equalizing pulse. Any other short pulse is a normal line sync.

Two equalizing pulses in a row arm the detector. Once armed, the vertical pulse is launched on the rising edge of the first broad pulse. If no broad pulse arrives, a timer measured from the last falling edge forces the pulse out instead. A separate watchdog on falling edges reports loss of sync, and while sync is lost the vertical output is held inactive.

Top module: `vsync_extract`

## Requirements
- R1: During reset and after it, `vsync_no` is 1 and `sync_lost_o` is 1. They stay so until the first filtered falling edge of `csync_ni`.
- R2: A stream of normal line syncs never drives `vsync_no` low. A normal line sync is a short low pulse whose falling edge comes at least 3*LINE_CLKS/4 clocks after the previous one.
- R3: Suppose the detector is armed and a broad low pulse ends, a broad pulse being one whose low time exceeds LINE_CLKS/4 clocks. Then `vsync_no` falls on the (GLITCH_LEN+3)th clock edge after the first edge that samples the rising input.
- R4: Each vertical pulse keeps `vsync_no` low for exactly VS_CLKS clocks, unless sync is lost during the pulse.
- R5: Each field gives exactly one vertical pulse. Broad or equalizing pulses that come after a launch are ignored until a normal line sync has been seen.
- R6: Suppose the detector is armed and no falling edge arrives. Then `vsync_no` falls on the (GLITCH_LEN+3+FORCE_CLKS)th clock edge after the edge that samples the last falling edge.
- R7: Arming needs EQ_MIN (2) consecutive equalizing pulses. An equalizing pulse has a low time of at most LINE_CLKS/4 clocks and comes less than 3*LINE_CLKS/4 clocks after the previous falling edge. With only one such pulse, no vertical pulse is forced.
- R8: A broad pulse that arrives while the detector is not armed has no effect on `vsync_no`.
- R9: A low time of exactly LINE_CLKS/4 clocks counts as equalizing, and a low time of LINE_CLKS/4+1 clocks counts as broad.
- R10: `sync_lost_o` rises on the (GLITCH_LEN+2+2*LINE_CLKS)th clock edge after the edge that samples the last falling edge. It clears on the (GLITCH_LEN+2)th edge after the edge that samples a new falling edge.
- R11: A low run shorter than GLITCH_LEN clocks is removed by the input filter. Such a run does not clear `sync_lost_o`.
- R12: While `sync_lost_o` is 1, `vsync_no` is 1. A vertical pulse in progress ends on the same clock that loss of sync is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csync_ni | input | 1 | Sliced composite sync, active low, asynchronous to the clock |
| vsync_no | output | 1 | Vertical sync pulse, active low |
| sync_lost_o | output | 1 | High while no falling edge has been seen for two lines |

## Verification
Every result has a fixed latency in clock edges, counted from the first edge that samples an input change:
- the edge-launched vertical pulse is due GLITCH_LEN+3 edges after that edge;
- the forced pulse is due FORCE_CLKS edges later than an edge-launched pulse would be;
- loss of sync rises GLITCH_LEN+2+2*LINE_CLKS edges after the last falling edge, and clears GLITCH_LEN+2 edges after a new one.

The bench drives the sync input on falling clock edges and samples the outputs on the same falling edge just before it drives. Each stimulus tick is therefore one cycle, and a state change made on rising edge n is seen at tick n+1. The bench records the exact tick of every output transition and compares it with the stimulus tick plus the latency above. Pulse widths and pulse counts are checked per field.

// File: rtl/vsx_pkg.sv
package vsx_pkg;
  typedef struct packed {
    logic pulse;  // a low pulse just ended
    logic broad;  // its low time exceeded a quarter line
    logic half;   // its falling edge came within three quarters of a line
    logic fall;   // a falling edge just occurred
  } pulse_ev_t;
endpackage

// File: rtl/vsx_in_filter.sv
module vsx_in_filter #(
  parameter int GLITCH_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(GLITCH_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          clean_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      run_q   <= '0;
      clean_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == clean_q) begin
        run_q <= '0;
      end else if (run_q == CW'(GLITCH_LEN - 1)) begin
        clean_q <= sync_q[1];
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign clean_o = clean_q;

  // the filtered level only moves after the synchronised input has held the new value
  AST_FILT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clean_q) |-> ($past(sync_q[1], 2) == clean_q)); // R11
endmodule

// File: rtl/vsx_pulse_class.sv
module vsx_pulse_class
  import vsx_pkg::*;
#(
  parameter int LINE_CLKS = 1716
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  output pulse_ev_t ev_o,
  output logic      los_o
);
  localparam int LOS_CLKS  = 2 * LINE_CLKS;
  localparam int CW        = $clog2(LOS_CLKS + 1);
  localparam int BROAD_MIN = LINE_CLKS / 4;
  localparam int HALF_MAX  = (3 * LINE_CLKS) / 4;

  logic          lvl_q;
  logic          fall_c, rise_c;
  logic [CW-1:0] gap_q, width_q;
  logic          half_q, los_q;
  pulse_ev_t     ev_q;

  assign fall_c = lvl_q & ~lvl_i;
  assign rise_c = ~lvl_q & lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b1;
      gap_q   <= CW'(LOS_CLKS);
      width_q <= '0;
      half_q  <= 1'b0;
      los_q   <= 1'b1;
      ev_q    <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (fall_c) begin
        gap_q   <= CW'(1);
        width_q <= CW'(1);
        half_q  <= (gap_q < CW'(HALF_MAX));
        los_q   <= 1'b0;
      end else begin
        if (gap_q != CW'(LOS_CLKS)) gap_q <= gap_q + 1'b1;
        else                        los_q <= 1'b1;
        if (!lvl_i && width_q != CW'(LOS_CLKS)) width_q <= width_q + 1'b1;
      end
      ev_q.fall  <= fall_c;
      ev_q.pulse <= rise_c;
      ev_q.broad <= (width_q > CW'(BROAD_MIN));
      ev_q.half  <= half_q;
    end
  end

  assign ev_o  = ev_q;
  assign los_o = los_q;

  AST_LOS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q.fall |-> !los_q); // R10
  AST_EV_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_q.pulse, ev_q.fall})); // R3
endmodule

// File: rtl/vsx_field_ctrl.sv
module vsx_field_ctrl
  import vsx_pkg::*;
#(
  parameter int EQ_MIN     = 2,
  parameter int FORCE_CLKS = 1620,
  parameter int VS_CLKS    = 5148
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pulse_ev_t ev_i,
  input  logic      los_i,
  output logic      vsync_no
);
  localparam int EW = $clog2(EQ_MIN + 1);
  localparam int TW = $clog2(FORCE_CLKS + 1);
  localparam int VW = $clog2(VS_CLKS + 1);

  logic [EW-1:0] eq_cnt_q;
  logic [TW-1:0] timer_q;
  logic [VW-1:0] vs_cnt_q;
  logic          done_q;
  logic          armed, vs_active, trig_edge, trig_force, fire;

  assign armed      = (eq_cnt_q == EW'(EQ_MIN));
  assign vs_active  = (vs_cnt_q != '0);
  assign trig_edge  = ev_i.pulse & ev_i.broad & armed & ~vs_active;
  assign trig_force = armed & (timer_q == TW'(FORCE_CLKS)) & ~vs_active;
  assign fire       = trig_edge | trig_force;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= TW'(FORCE_CLKS);
    end else if (ev_i.fall) begin
      timer_q <= TW'(1);
    end else if (timer_q != TW'(FORCE_CLKS)) begin
      timer_q <= timer_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_cnt_q <= '0;
      vs_cnt_q <= '0;
      done_q   <= 1'b0;
    end else if (los_i) begin
      eq_cnt_q <= '0;
      vs_cnt_q <= '0;
      done_q   <= 1'b0;
    end else if (fire) begin
      vs_cnt_q <= VW'(VS_CLKS);
      eq_cnt_q <= '0;
      done_q   <= 1'b1;
    end else begin
      if (vs_active) vs_cnt_q <= vs_cnt_q - 1'b1;
      if (ev_i.pulse) begin
        if (ev_i.broad) begin
          eq_cnt_q <= '0;
        end else if (ev_i.half) begin
          if (!done_q && !armed) eq_cnt_q <= eq_cnt_q + 1'b1;
        end else begin
          eq_cnt_q <= '0;
          done_q   <= 1'b0;
        end
      end
    end
  end

  assign vsync_no = ~(vs_active & ~los_i);

  AST_TRIG_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vs_active) |-> ($past(eq_cnt_q) == EW'(EQ_MIN))); // R7
  AST_NO_RETRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(vs_active) && !$past(los_i)) |-> (vs_cnt_q == $past(vs_cnt_q) - VW'(1))); // R5
  AST_LOS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(los_i) |-> !vs_active); // R12
endmodule

// File: rtl/vsync_extract.sv
module vsync_extract
  import vsx_pkg::*;
#(
  parameter int LINE_CLKS  = 1716,
  parameter int GLITCH_LEN = 4,
  parameter int EQ_MIN     = 2,
  parameter int FORCE_CLKS = 1620,
  parameter int VS_CLKS    = 5148
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_ni,
  output logic vsync_no,
  output logic sync_lost_o
);
  logic      lvl;
  pulse_ev_t ev;
  logic      los;

  vsx_in_filter #(.GLITCH_LEN(GLITCH_LEN)) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (csync_ni),
    .clean_o (lvl)
  );

  vsx_pulse_class #(.LINE_CLKS(LINE_CLKS)) u_class (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .ev_o   (ev),
    .los_o  (los)
  );

  vsx_field_ctrl #(
    .EQ_MIN     (EQ_MIN),
    .FORCE_CLKS (FORCE_CLKS),
    .VS_CLKS    (VS_CLKS)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .los_i    (los),
    .vsync_no (vsync_no)
  );

  assign sync_lost_o = los;
endmodule

// File: tb/vsync_extract_tb.sv
module vsync_extract_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINE  = 64;
  localparam int GL    = 3;
  localparam int FORCE = 60;
  localparam int VSW   = 192;
  localparam int LAT   = GL + 4;          // stimulus tick to observed output change
  localparam int LOSL  = GL + 3 + 2 * LINE;
  localparam int CLRL  = GL + 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic csync_ni = 1'b1;
  logic vsync_no, sync_lost_o;

  int total = 0, failed = 0;
  int cyc = 0;
  int vs_falls = 0, vs_fall_t = -1, vs_rise_t = -1;
  int los_rise_t = -1, los_fall_t = -1;
  int in_fall = 0, in_rise = 0;
  logic vs_last = 1'b1, los_last = 1'b1;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vsync_extract #(
    .LINE_CLKS(LINE), .GLITCH_LEN(GL), .EQ_MIN(2), .FORCE_CLKS(FORCE), .VS_CLKS(VSW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .csync_ni(csync_ni),
    .vsync_no(vsync_no), .sync_lost_o(sync_lost_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic v);
    @(negedge clk);
    if (!vsync_no && vs_last) begin vs_falls++; vs_fall_t = cyc; end
    if (vsync_no && !vs_last) vs_rise_t = cyc;
    if (sync_lost_o && !los_last) los_rise_t = cyc;
    if (!sync_lost_o && los_last) los_fall_t = cyc;
    vs_last  = vsync_no;
    los_last = sync_lost_o;
    csync_ni = v;
    cyc++;
  endtask

  task automatic hold(input logic v, input int n);
    repeat (n) tick(v);
  endtask

  task automatic pulse(input int lo, input int per);
    in_fall = cyc;
    repeat (lo) tick(1'b0);
    in_rise = cyc;
    repeat (per - lo) tick(1'b1);
  endtask

  task automatic lines(input int n);
    repeat (n) pulse(4, LINE);
  endtask

  task automatic eqs(input int n);
    repeat (n) pulse(4, LINE / 2);
  endtask

  initial begin
    int base, tr, tf, first_fall;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 vsync_no in reset", vsync_no, 1);
    chk("R1 sync_lost_o in reset", sync_lost_o, 1);
    rst_ni = 1'b1;
    hold(1'b1, 10);
    chk("R1 sync_lost_o after reset", sync_lost_o, 1);

    // R2 normal lines, R10 clear latency
    base = vs_falls;
    first_fall = cyc;
    lines(10);
    chk("R10 los clear tick", los_fall_t, first_fall + CLRL);
    chk("R2 no vsync on normal lines", vs_falls - base, 0);

    // R3 R4 R5 full field with serration
    base = vs_falls;
    eqs(6);
    pulse(27, LINE / 2);
    tr = in_rise;
    repeat (5) pulse(27, LINE / 2);
    eqs(6);
    lines(8);
    chk("R3 edge trigger tick", vs_fall_t, tr + LAT);
    chk("R4 pulse width", vs_rise_t - vs_fall_t, VSW);
    chk("R5 one pulse per field", vs_falls - base, 1);

    // R6 forced pulse without serration
    base = vs_falls;
    eqs(5);
    pulse(4, LINE);
    tf = in_fall;
    lines(6);
    chk("R6 forced tick", vs_fall_t, tf + LAT + FORCE);
    chk("R4 forced width", vs_rise_t - vs_fall_t, VSW);
    chk("R5 one forced pulse", vs_falls - base, 1);

    // R7 one equalizing pulse only
    base = vs_falls;
    pulse(4, LINE / 2);
    pulse(4, LINE);
    lines(6);
    chk("R7 single eq no pulse", vs_falls - base, 0);

    // R8 broad pulse while not armed
    base = vs_falls;
    pulse(27, LINE);
    lines(6);
    chk("R8 unarmed broad no pulse", vs_falls - base, 0);

    // R9 boundary: quarter line plus one is broad
    base = vs_falls;
    eqs(3);
    pulse(LINE / 4 + 1, LINE / 2);
    tr = in_rise;
    lines(6);
    chk("R9 width q+1 triggers at rise", vs_fall_t, tr + LAT);
    // exactly a quarter line is equalizing, so only the timer launches
    eqs(3);
    pulse(LINE / 4, LINE);
    tf = in_fall;
    lines(6);
    chk("R9 width q forced tick", vs_fall_t, tf + LAT + FORCE);
    chk("R9 two pulses in boundary test", vs_falls - base, 2);

    // R10 loss of sync, R11 glitch rejection
    tf = in_fall;
    hold(1'b1, 200);
    chk("R10 los rise tick", los_rise_t, tf + LOSL);
    hold(1'b0, GL - 1);
    hold(1'b1, 20);
    chk("R11 glitch keeps los", sync_lost_o, 1);
    first_fall = cyc;
    lines(4);
    chk("R10 los clear after return", los_fall_t, first_fall + CLRL);

    // R12 loss of sync cuts a pulse in progress
    eqs(6);
    pulse(27, LINE / 2);
    tr = in_rise;
    tf = in_fall;
    hold(1'b1, 250);
    chk("R3 trigger before loss", vs_fall_t, tr + LAT);
    chk("R12 pulse ends at loss", vs_rise_t, los_rise_t);
    chk("R12 loss tick", los_rise_t, tf + LOSL);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule